// File: doc/BRIEF.md
# Binary32 NaN Classify and Quiet Unit

This unit looks at one binary32 operand at a time and decides whether it is a NaN and, if so, which kind. It also produces a quieted copy of the operand and the default NaN word. One input picks how the top fraction bit is read, and this can change on every operand. When that input is low, a set top fraction bit marks a quiet NaN. When it is high, a set top fraction bit marks a signaling NaN. A second input picks between two default NaN patterns. It only has an effect while the top-bit-quiet convention is in force.

An operand is taken on each clock edge where `in_valid` is high. All results appear in registers one cycle later, and `out_valid` marks them. When `in_valid` is low the result registers keep their values. Floating-point arithmetic, traps and other widths are left to the units that use these results.

Top module: `nan_sieve`

## Requirements
- R1: While `rst` is high at a clock edge, every output register clears to zero, `out_valid` included.
- R2: `out_valid` equals the `in_valid` of the previous edge. After an edge where `in_valid` was low, all data outputs keep their previous values.
- R3: With `snan_hi` = 0, an operand whose exponent bits [30:23] are all ones is classified by fraction bit 22. If bit 22 is 1, the operand is a quiet NaN. If bit 22 is 0 and bits [21:0] are not all zero, it is a signaling NaN.
- R4: With `snan_hi` = 1 the two classes swap. Exponent all ones with bit 22 = 1 is a signaling NaN. Exponent all ones with bit 22 = 0 and bits [21:0] not zero is a quiet NaN.
- R5: `out_nan` is 1 exactly when one of `out_qnan` or `out_snan` is 1, and those two flags are never both 1. Infinities (exponent all ones, fraction zero) and all finite values give 0 on all three flags.
- R6: With `snan_hi` = 0, a signaling NaN is quieted by setting bit 22. The sign and every other bit are kept.
- R7: With `snan_hi` = 1, the quieted result of a signaling NaN is the default NaN of that convention.
- R8: Any operand that is not a signaling NaN appears unchanged on `out_quiet`.
- R9: With `snan_hi` = 0, `out_dflt` is 0x7FC00000 when `dflt_full` = 0 and 0x7FFFFFFF when `dflt_full` = 1.
- R10: With `snan_hi` = 1, `out_dflt` is 0x7FBFFFFF whatever the value of `dflt_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| in_word | input | 32 | Binary32 operand |
| snan_hi | input | 1 | 1: a set fraction MSB marks a signaling NaN |
| dflt_full | input | 1 | Default NaN with all fraction bits set (only when `snan_hi` = 0) |
| out_valid | output | 1 | Results are for the operand of the previous edge |
| out_nan | output | 1 | Operand was a NaN |
| out_qnan | output | 1 | Operand was a quiet NaN |
| out_snan | output | 1 | Operand was a signaling NaN |
| out_quiet | output | 32 | Quieted operand |
| out_dflt | output | 32 | Default NaN for the chosen convention |

## Verification
The clearest collision happens when a signaling NaN arrives under `snan_hi` = 1 while `dflt_full` is high. In that one cycle, quieting and default-NaN selection both act on the same word. The quieted result must be 0x7FBFFFFF, not the all-ones pattern, and `out_dflt` must agree with it. The bench drives this directly. It also runs a long random stream that flips the polarity and the default mode on every operand, with many operands near the NaN and infinity encodings. Each cycle's outputs are compared with a behavioural model that works out the class, the quieted word and the default word separately for each convention.

// File: rtl/nan_sieve_pkg.sv
package nan_sieve_pkg;
   typedef struct packed {
      logic nan;
      logic qnan;
      logic snan;
   } nan_flags_t;
endpackage

// File: rtl/nan_sieve_classify.sv
module nan_sieve_classify #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0]   word,
   input  logic                    snan_hi,
   output nan_sieve_pkg::nan_flags_t flags
);
   localparam int WORD_W = 1 + EXP_W + FRAC_W;
   localparam int TOP_F  = FRAC_W - 1;

   logic exp_ones, top_bit, rest_nz;
   logic top_nan, low_nan;

   always_comb begin
      exp_ones = &word[WORD_W-2 -: EXP_W];
      top_bit  = word[TOP_F];
      rest_nz  = |word[TOP_F-1:0];
      top_nan  = exp_ones & top_bit;
      low_nan  = exp_ones & ~top_bit & rest_nz;
      flags.nan  = top_nan | low_nan;
      flags.qnan = snan_hi ? low_nan : top_nan;
      flags.snan = snan_hi ? top_nan : low_nan;
   end
endmodule

// File: rtl/nan_sieve_dflt.sv
module nan_sieve_dflt #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic                  snan_hi,
   input  logic                  dflt_full,
   output logic [EXP_W+FRAC_W:0] word
);
   localparam int WORD_W = 1 + EXP_W + FRAC_W;
   localparam int TOP_F  = FRAC_W - 1;

   logic fill;
   assign fill = snan_hi | dflt_full;

   assign word[WORD_W-1]            = 1'b0;
   assign word[WORD_W-2 -: EXP_W]   = {EXP_W{1'b1}};

   for (genvar i = 0; i < FRAC_W; i++) begin : g_frac
      if (i == TOP_F) begin : g_top
         assign word[i] = ~snan_hi;
      end else begin : g_low
         assign word[i] = fill;
      end
   end
endmodule

// File: rtl/nan_sieve_quiet.sv
module nan_sieve_quiet #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] word,
   input  logic                  is_snan,
   input  logic                  snan_hi,
   input  logic [EXP_W+FRAC_W:0] dflt,
   output logic [EXP_W+FRAC_W:0] quiet
);
   localparam int WORD_W = 1 + EXP_W + FRAC_W;
   localparam logic [WORD_W-1:0] TOP_MASK = WORD_W'(1) << (FRAC_W - 1);

   always_comb begin
      if (!is_snan)      quiet = word;
      else if (snan_hi)  quiet = dflt;
      else               quiet = word | TOP_MASK;
   end
endmodule

// File: rtl/nan_sieve.sv
module nan_sieve #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        in_valid,
   input  logic [31:0] in_word,
   input  logic        snan_hi,
   input  logic        dflt_full,
   output logic        out_valid,
   output logic        out_nan,
   output logic        out_qnan,
   output logic        out_snan,
   output logic [31:0] out_quiet,
   output logic [31:0] out_dflt
);
   localparam int WORD_W = 1 + EXP_W + FRAC_W;

   if (WORD_W != 32) begin : g_bad_width
      $error("nan_sieve: exponent and fraction widths must total a 32-bit word");
   end
   if (EXP_W < 2 || FRAC_W < 2) begin : g_bad_field
      $error("nan_sieve: fields need at least two bits");
   end

   nan_sieve_pkg::nan_flags_t flags_c;
   logic [WORD_W-1:0] dflt_c, quiet_c;

   nan_sieve_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word(in_word), .snan_hi(snan_hi), .flags(flags_c));

   nan_sieve_dflt #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dflt (
      .snan_hi(snan_hi), .dflt_full(dflt_full), .word(dflt_c));

   nan_sieve_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_qt (
      .word(in_word), .is_snan(flags_c.snan), .snan_hi(snan_hi),
      .dflt(dflt_c), .quiet(quiet_c));

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_nan   <= 1'b0;
         out_qnan  <= 1'b0;
         out_snan  <= 1'b0;
         out_quiet <= '0;
         out_dflt  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_nan   <= flags_c.nan;
            out_qnan  <= flags_c.qnan;
            out_snan  <= flags_c.snan;
            out_quiet <= quiet_c;
            out_dflt  <= dflt_c;
         end
      end
   end
endmodule

// File: rtl/nan_sieve_chk.sv
module nan_sieve_chk (
   input logic        clk,
   input logic        rst,
   input logic        in_valid,
   input logic [31:0] in_word,
   input logic        snan_hi,
   input logic        out_valid,
   input logic        out_nan,
   input logic        out_qnan,
   input logic        out_snan,
   input logic [31:0] out_quiet,
   input logic [31:0] out_dflt
);
   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   // R2
   valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   // R5
   flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({out_qnan, out_snan}));
   // R5
   nan_union_chk: assert property (@(posedge clk) disable iff (rst)
      out_nan == (out_qnan | out_snan));
   // R8
   passthru_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid && !(&in_word[30:23] && (in_word[22] ? snan_hi : (!snan_hi && |in_word[21:0])))
      |=> out_quiet == $past(in_word));
   // R7
   inv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid && snan_hi && &in_word[30:23] && in_word[22]
      |=> out_quiet == out_dflt && out_snan);
   // R6
   norm_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid && !snan_hi && &in_word[30:23] && !in_word[22] && |in_word[21:0]
      |=> out_quiet == ($past(in_word) | 32'h0040_0000));
   // R2
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid && !$past(rst) |=> $stable(out_quiet) && $stable(out_dflt));
endmodule

bind nan_sieve nan_sieve_chk u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
   .snan_hi(snan_hi), .out_valid(out_valid), .out_nan(out_nan),
   .out_qnan(out_qnan), .out_snan(out_snan), .out_quiet(out_quiet),
   .out_dflt(out_dflt));

// File: tb/sim_nan_sieve.sv
`timescale 1ns/1ps
module sim_nan_sieve;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] in_word = '0;
   logic        snan_hi = 1'b0;
   logic        dflt_full = 1'b0;
   logic        out_valid, out_nan, out_qnan, out_snan;
   logic [31:0] out_quiet, out_dflt;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // expected registered state
   logic        e_valid = 0, e_nan = 0, e_q = 0, e_s = 0, e_pol = 0;
   logic [31:0] e_quiet = '0, e_dflt = '0;

   always #2 clk = ~clk;

   nan_sieve u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
      .snan_hi(snan_hi), .dflt_full(dflt_full), .out_valid(out_valid),
      .out_nan(out_nan), .out_qnan(out_qnan), .out_snan(out_snan),
      .out_quiet(out_quiet), .out_dflt(out_dflt));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R2 valid", 32'(out_valid), 32'(e_valid));
      chk(e_pol ? "R4 qnan" : "R3 qnan", 32'(out_qnan), 32'(e_q));
      chk(e_pol ? "R4 snan" : "R3 snan", 32'(out_snan), 32'(e_s));
      chk("R5 nan", 32'(out_nan), 32'(e_nan));
      chk(e_s ? (e_pol ? "R7 quiet" : "R6 quiet") : "R8 quiet", out_quiet, e_quiet);
      chk(e_pol ? "R10 dflt" : "R9 dflt", out_dflt, e_dflt);
   endtask

   task automatic step(bit v, logic [31:0] w, bit p, bit a);
      bit ex, topb, lown, q, s;
      logic [31:0] d;
      @(negedge clk);
      compare_all();
      in_valid = v; in_word = w; snan_hi = p; dflt_full = a;
      e_valid = v;
      if (v) begin
         ex   = (w[30:23] == 8'hFF);
         topb = ex && w[22];
         lown = ex && !w[22] && (w[21:0] != 0);
         q = p ? lown : topb;
         s = p ? topb : lown;
         if (p)      d = 32'h7FBF_FFFF;
         else if (a) d = 32'h7FFF_FFFF;
         else        d = 32'h7FC0_0000;
         e_q = q; e_s = s; e_nan = q | s; e_pol = p; e_dflt = d;
         e_quiet = !s ? w : (p ? d : (w | 32'h0040_0000));
      end
   endtask

   function automatic logic [31:0] pick_word();
      logic [31:0] r = $urandom();
      case (r[3:2])
         2'd0: return {r[31], 8'hFF, r[22:0]};
         2'd1: return {r[31], 8'hFF, r[22], 22'(r[1:0] == 0 ? 0 : 1) << r[8:4]};
         2'd2: return {r[31], 8'hFF, 23'h0};
         default: return r;
      endcase
   endfunction

   initial begin : watchdog
      #(4 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(7));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 valid", 32'(out_valid), 0);
      chk("R1 flags", {29'd0, out_nan, out_qnan, out_snan}, 0);
      chk("R1 quiet", out_quiet, 0);
      chk("R1 dflt", out_dflt, 0);
      rst = 1'b0;
      // normal polarity, R3 R6 R8 R9
      step(1, 32'h7FC0_0001, 0, 0);
      step(1, 32'h7F80_0001, 0, 0);
      step(1, 32'hFFA0_1234, 0, 0);
      step(1, 32'h7F80_0000, 0, 0);
      step(1, 32'hFF80_0000, 0, 0);
      step(1, 32'h3F80_0000, 0, 1);
      step(1, 32'h7F80_0001, 0, 1);
      step(0, 32'h7FC0_0000, 1, 0);
      step(0, 32'h0000_0000, 0, 1);
      // inverted polarity, R4 R7 R10
      step(1, 32'h7FC0_0000, 1, 0);
      step(1, 32'hFFE0_0005, 1, 1);
      step(1, 32'h7F80_0001, 1, 1);
      step(1, 32'h7F80_0000, 1, 0);
      step(1, 32'hFFBF_FFFF, 1, 0);
      step(1, 32'h0000_0001, 1, 1);
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r = $urandom();
         step(r[0] | r[1], pick_word(), r[2], r[3]);
      end
      step(0, 32'h0, 0, 0);
      step(0, 32'h0, 0, 0);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule